// File: doc/BRIEF.md
# Protection Fault Response Controller

This block sits between the debounced protection comparators of a three-phase gate driver and its output stage. It watches six per-switch overcurrent flags (high and low side of phases A, B and C), supply undervoltage, overtemperature shutdown, overtemperature warning and an interface fault. For each protective class it applies a programmed response: automatic recovery after a slow or fast retry interval, a latch that holds until cleared, a report without touching the driver, or no response at all.

It produces an active-low fault indication, a request to put the power stage into high impedance, a device-fault summary bit and sticky status bits. Retry intervals are counted in ticks from an internal prescaler. Each interval comes from one of two four-entry tables, and all eight entries are parameters. A one-cycle clear input releases latched faults and wipes sticky status, but only for conditions that are no longer present.

Top module: `fault_resp_ctrl`

## Requirements
- R1: After synchronous reset `fault_n_o`=1, `drv_hiz_o`=0, `dev_fault_o`=0 and every status bit is 0.
- R2: Overcurrent mode 0 and mode 1 report the fault and request high impedance while the input is high. After the input falls they release both outputs once the retry interval expires. Mode 0 uses the slow table and mode 1 uses the fast table.
- R3: Overcurrent mode 2 reports the fault and requests high impedance, then holds both after the input falls, until a clear arrives while the input is low.
- R4: Overcurrent mode 3 reports the fault while the input is high and never requests high impedance.
- R5: Overcurrent mode 7 disables the class: no report, no high impedance and no status bit.
- R6: Reserved codes behave like the fast auto-retry mode. For overcurrent these are codes 4 to 6. For the 2-bit undervoltage and overtemperature modes, code 0 selects slow retry and codes 1 to 3 select fast retry.
- R7: `slow_sel_i`/`fast_sel_i` codes 0..3 pick table entries 0..3. With a tick every P cycles and T ticks selected, outputs release between 4+(T-1)·P and 3+T·P rising edges after the first edge that sees the input low.
- R8: If the fault returns during the retry interval, the interval is abandoned, high impedance stays asserted, and a full interval restarts when the input falls again.
- R9: The overtemperature warning always sets its sticky bit. It drives the fault output only while `otw_en_i`=1, and it never requests high impedance.
- R10: With `spi_dis_i`=0 the interface fault is reported while its input is high and sets its sticky bit. With `spi_dis_i`=1 it has no effect on any output.
- R11: `oc_sts_o` holds six sticky bits: [0],[1],[2] are the high sides of A, B, C, and [3],[4],[5] are the low sides of A, B, C.
- R12: `dev_fault_o` is the complement of `fault_n_o`. It is 1 whenever an enabled fault is active, retrying or latched, and high impedance is never requested without it.
- R13: A clear pulse resets only those sticky bits whose input is low. A clear while the input is high leaves the bit and any latched fault in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| oc_hs_i | input | 3 | High-side overcurrent, phases A..C |
| oc_ls_i | input | 3 | Low-side overcurrent, phases A..C |
| uv_i | input | 1 | Supply undervoltage |
| ot_sd_i | input | 1 | Overtemperature shutdown |
| otw_i | input | 1 | Overtemperature warning |
| spi_flt_i | input | 1 | Serial interface fault |
| oc_mode_i | input | 3 | Overcurrent response mode |
| uv_mode_i | input | 2 | Undervoltage response mode |
| ot_mode_i | input | 2 | Overtemperature response mode |
| otw_en_i | input | 1 | Warning reporting enable |
| spi_dis_i | input | 1 | Interface fault ignore |
| slow_sel_i | input | 2 | Slow retry table index |
| fast_sel_i | input | 2 | Fast retry table index |
| clear_i | input | 1 | Clear pulse |
| fault_n_o | output | 1 | Active-low fault indication |
| drv_hiz_o | output | 1 | Power stage high-impedance request |
| dev_fault_o | output | 1 | Device-fault summary |
| oc_sts_o | output | 6 | Sticky per-switch overcurrent status |
| uv_sts_o | output | 1 | Sticky undervoltage status |
| ot_sts_o | output | 1 | Sticky overtemperature shutdown status |
| otw_sts_o | output | 1 | Sticky warning status |
| spi_sts_o | output | 1 | Sticky interface fault status |

## Verification
A sticky bit changes one rising edge after its input or a clear is seen. The fault, high-impedance and summary outputs change two edges after an input change, because a channel state register sits ahead of the output register. The bench drives stimulus on the falling edge and samples just after the rising edge that the count names. Retry release depends on the free-running tick phase, so it is not checked at one cycle. The bench instead counts edges until the high-impedance request drops and requires the count to fall inside the R7 window.

// File: rtl/fault_resp_pkg.sv
`timescale 1ns/1ps
package fault_resp_pkg;

  // Decoded response for one protective class
  typedef struct packed {
    logic en;     // class participates at all
    logic hiz;    // power stage goes high impedance
    logic latch;  // hold until cleared
    logic slow;   // use slow retry table
  } resp_t;

  typedef enum logic [1:0] {
    CH_IDLE   = 2'd0,
    CH_ACTIVE = 2'd1,
    CH_RETRY  = 2'd2,
    CH_LATCH  = 2'd3
  } chan_st_t;

  // 3-bit overcurrent mode; reserved codes fall back to fast retry
  function automatic resp_t oc_resp(input logic [2:0] m);
    resp_t r;
    case (m)
      3'd0:    r = '{en: 1'b1, hiz: 1'b1, latch: 1'b0, slow: 1'b1};
      3'd1:    r = '{en: 1'b1, hiz: 1'b1, latch: 1'b0, slow: 1'b0};
      3'd2:    r = '{en: 1'b1, hiz: 1'b1, latch: 1'b1, slow: 1'b0};
      3'd3:    r = '{en: 1'b1, hiz: 1'b0, latch: 1'b0, slow: 1'b0};
      3'd7:    r = '{en: 1'b0, hiz: 1'b0, latch: 1'b0, slow: 1'b0};
      default: r = '{en: 1'b1, hiz: 1'b1, latch: 1'b0, slow: 1'b0};
    endcase
    return r;
  endfunction

  // 2-bit supply/thermal mode; only slow/fast are defined
  function automatic resp_t sup_resp(input logic [1:0] m);
    resp_t r;
    r = '{en: 1'b1, hiz: 1'b1, latch: 1'b0, slow: (m == 2'd0)};
    return r;
  endfunction

endpackage

// File: rtl/frc_tick_gen.sv
`timescale 1ns/1ps
module frc_tick_gen #(
  parameter int unsigned DIV = 1000
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/frc_retry_lut.sv
`timescale 1ns/1ps
module frc_retry_lut #(
  parameter int unsigned W  = 23,
  parameter int unsigned S0 = 500000,
  parameter int unsigned S1 = 1000000,
  parameter int unsigned S2 = 2000000,
  parameter int unsigned S3 = 5000000,
  parameter int unsigned F0 = 500,
  parameter int unsigned F1 = 1000,
  parameter int unsigned F2 = 2000,
  parameter int unsigned F3 = 5000
) (
  input  logic [1:0]   slow_sel_i,
  input  logic [1:0]   fast_sel_i,
  output logic [W-1:0] slow_ticks_o,
  output logic [W-1:0] fast_ticks_o
);
  localparam logic [W-1:0] SLOW_TAB [4] = '{W'(S0), W'(S1), W'(S2), W'(S3)};
  localparam logic [W-1:0] FAST_TAB [4] = '{W'(F0), W'(F1), W'(F2), W'(F3)};

  assign slow_ticks_o = SLOW_TAB[slow_sel_i];
  assign fast_ticks_o = FAST_TAB[fast_sel_i];
endmodule

// File: rtl/frc_channel.sv
`timescale 1ns/1ps
module frc_channel
  import fault_resp_pkg::*;
#(
  parameter int unsigned W = 23
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_i,
  input  logic         flt_i,
  input  resp_t        act_i,
  input  logic         clear_i,
  input  logic [W-1:0] slow_ticks_i,
  input  logic [W-1:0] fast_ticks_i,
  output logic         engaged_o,
  output logic         hiz_o
);
  chan_st_t     st_q;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= CH_IDLE;
      cnt_q <= '0;
    end else if (!act_i.en) begin
      st_q  <= CH_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        CH_IDLE: begin
          if (flt_i) st_q <= CH_ACTIVE;
        end
        CH_ACTIVE: begin
          if (!flt_i) begin
            if (act_i.latch) begin
              st_q <= CH_LATCH;
            end else if (!act_i.hiz) begin
              st_q <= CH_IDLE;
            end else begin
              st_q  <= CH_RETRY;
              cnt_q <= act_i.slow ? slow_ticks_i : fast_ticks_i;
            end
          end
        end
        CH_RETRY: begin
          if (flt_i)              st_q  <= CH_ACTIVE;
          else if (cnt_q == '0)   st_q  <= CH_IDLE;
          else if (tick_i)        cnt_q <= cnt_q - 1'b1;
        end
        CH_LATCH: begin
          if (flt_i)        st_q <= CH_ACTIVE;
          else if (clear_i) st_q <= CH_IDLE;
        end
        default: st_q <= CH_IDLE;
      endcase
    end
  end

  assign engaged_o = (st_q != CH_IDLE);
  assign hiz_o     = engaged_o & act_i.hiz;
endmodule

// File: rtl/fault_resp_ctrl.sv
`timescale 1ns/1ps
module fault_resp_ctrl
  import fault_resp_pkg::*;
#(
  parameter int unsigned TICK_DIV = 1000,
  parameter int unsigned TIMER_W  = 23,
  parameter int unsigned SLOW_T0  = 500000,
  parameter int unsigned SLOW_T1  = 1000000,
  parameter int unsigned SLOW_T2  = 2000000,
  parameter int unsigned SLOW_T3  = 5000000,
  parameter int unsigned FAST_T0  = 500,
  parameter int unsigned FAST_T1  = 1000,
  parameter int unsigned FAST_T2  = 2000,
  parameter int unsigned FAST_T3  = 5000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] oc_hs_i,
  input  logic [2:0] oc_ls_i,
  input  logic       uv_i,
  input  logic       ot_sd_i,
  input  logic       otw_i,
  input  logic       spi_flt_i,
  input  logic [2:0] oc_mode_i,
  input  logic [1:0] uv_mode_i,
  input  logic [1:0] ot_mode_i,
  input  logic       otw_en_i,
  input  logic       spi_dis_i,
  input  logic [1:0] slow_sel_i,
  input  logic [1:0] fast_sel_i,
  input  logic       clear_i,
  output logic       fault_n_o,
  output logic       drv_hiz_o,
  output logic       dev_fault_o,
  output logic [5:0] oc_sts_o,
  output logic       uv_sts_o,
  output logic       ot_sts_o,
  output logic       otw_sts_o,
  output logic       spi_sts_o
);
  localparam int unsigned NPH  = 3;
  localparam int unsigned NSW  = 2 * NPH;
  localparam int unsigned NCLS = 3;   // overcurrent, undervoltage, shutdown

  logic               tick;
  logic [TIMER_W-1:0] slow_ticks, fast_ticks;
  logic [NSW-1:0]     oc_raw;
  resp_t              cls_act [NCLS];
  logic [NCLS-1:0]    cls_flt, cls_eng, cls_hiz;

  assign oc_raw = {oc_ls_i, oc_hs_i};

  assign cls_flt[0] = |oc_raw;
  assign cls_flt[1] = uv_i;
  assign cls_flt[2] = ot_sd_i;
  assign cls_act[0] = oc_resp(oc_mode_i);
  assign cls_act[1] = sup_resp(uv_mode_i);
  assign cls_act[2] = sup_resp(ot_mode_i);

  frc_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  frc_retry_lut #(
    .W (TIMER_W),
    .S0(SLOW_T0), .S1(SLOW_T1), .S2(SLOW_T2), .S3(SLOW_T3),
    .F0(FAST_T0), .F1(FAST_T1), .F2(FAST_T2), .F3(FAST_T3)
  ) u_lut (
    .slow_sel_i   (slow_sel_i),
    .fast_sel_i   (fast_sel_i),
    .slow_ticks_o (slow_ticks),
    .fast_ticks_o (fast_ticks)
  );

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    frc_channel #(.W(TIMER_W)) u_ch (
      .clk          (clk),
      .rst          (rst),
      .tick_i       (tick),
      .flt_i        (cls_flt[c]),
      .act_i        (cls_act[c]),
      .clear_i      (clear_i),
      .slow_ticks_i (slow_ticks),
      .fast_ticks_i (fast_ticks),
      .engaged_o    (cls_eng[c]),
      .hiz_o        (cls_hiz[c])
    );
  end

  // Sticky per-switch overcurrent bits; set has priority over clear
  for (genvar s = 0; s < NSW; s++) begin : g_oc_sts
    always_ff @(posedge clk) begin
      if (rst)                              oc_sts_o[s] <= 1'b0;
      else if (oc_raw[s] && cls_act[0].en)  oc_sts_o[s] <= 1'b1;
      else if (clear_i)                     oc_sts_o[s] <= 1'b0;
    end
  end

  logic [3:0] misc_set, misc_q;
  assign misc_set = {spi_flt_i & ~spi_dis_i, otw_i, ot_sd_i, uv_i};

  for (genvar k = 0; k < 4; k++) begin : g_misc_sts
    always_ff @(posedge clk) begin
      if (rst)              misc_q[k] <= 1'b0;
      else if (misc_set[k]) misc_q[k] <= 1'b1;
      else if (clear_i)     misc_q[k] <= 1'b0;
    end
  end

  assign uv_sts_o  = misc_q[0];
  assign ot_sts_o  = misc_q[1];
  assign otw_sts_o = misc_q[2];
  assign spi_sts_o = misc_q[3];

  logic rpt_next, hiz_next;
  assign rpt_next = (|cls_eng) | (otw_i & otw_en_i) | (spi_flt_i & ~spi_dis_i);
  assign hiz_next = |cls_hiz;

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_n_o   <= 1'b1;
      dev_fault_o <= 1'b0;
      drv_hiz_o   <= 1'b0;
    end else begin
      fault_n_o   <= ~rpt_next;
      dev_fault_o <= rpt_next;
      drv_hiz_o   <= hiz_next;
    end
  end
endmodule

// File: rtl/fault_resp_ctrl_chk.sv
`timescale 1ns/1ps
module fault_resp_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] oc_hs_i,
  input logic [2:0] oc_ls_i,
  input logic       uv_i,
  input logic       ot_sd_i,
  input logic       otw_i,
  input logic       spi_flt_i,
  input logic [2:0] oc_mode_i,
  input logic [1:0] uv_mode_i,
  input logic [1:0] ot_mode_i,
  input logic       otw_en_i,
  input logic       spi_dis_i,
  input logic [1:0] slow_sel_i,
  input logic [1:0] fast_sel_i,
  input logic       clear_i,
  input logic       fault_n_o,
  input logic       drv_hiz_o,
  input logic       dev_fault_o,
  input logic [5:0] oc_sts_o,
  input logic       uv_sts_o,
  input logic       ot_sts_o,
  input logic       otw_sts_o,
  input logic       spi_sts_o
);
  // High impedance is never requested silently
  p_hiz_reported_r12: assert property (@(posedge clk) disable iff (rst)
    drv_hiz_o |-> !fault_n_o);

  // Undervoltage reaches the summary two edges later
  p_uv_summary_r12: assert property (@(posedge clk) disable iff (rst)
    uv_i |-> ##2 dev_fault_o);

  // Enabled high-side A overcurrent sets its own sticky bit
  p_oc_bit_set_r11: assert property (@(posedge clk) disable iff (rst)
    (oc_hs_i[0] && oc_mode_i != 3'd7) |=> oc_sts_o[0]);

  // Without a clear no sticky bit falls
  p_sticky_hold_r13: assert property (@(posedge clk) disable iff (rst)
    !clear_i |=> ((oc_sts_o & $past(oc_sts_o)) == $past(oc_sts_o)));

  // Clear with the input low empties the undervoltage bit
  p_uv_clear_r13: assert property (@(posedge clk) disable iff (rst)
    (clear_i && !uv_i) |=> !uv_sts_o);

  // Ignored interface fault leaves its sticky bit alone
  p_spi_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (spi_flt_i && spi_dis_i && !spi_sts_o) |=> !spi_sts_o);
endmodule

bind fault_resp_ctrl fault_resp_ctrl_chk u_chk (.*);

// File: tb/fault_resp_ctrl_test.sv
`timescale 1ns/1ps
module fault_resp_ctrl_test;
  localparam int P = 3;
  localparam int ST [4] = '{6, 8, 10, 12};
  localparam int FT [4] = '{2, 3, 4, 5};

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst = 1'b1;
  logic [2:0] oc_hs_i = '0, oc_ls_i = '0;
  logic       uv_i = 0, ot_sd_i = 0, otw_i = 0, spi_flt_i = 0;
  logic [2:0] oc_mode_i = 3'd1;
  logic [1:0] uv_mode_i = 2'd1, ot_mode_i = 2'd1;
  logic       otw_en_i = 0, spi_dis_i = 0;
  logic [1:0] slow_sel_i = 0, fast_sel_i = 0;
  logic       clear_i = 0;
  logic       fault_n_o, drv_hiz_o, dev_fault_o;
  logic [5:0] oc_sts_o;
  logic       uv_sts_o, ot_sts_o, otw_sts_o, spi_sts_o;

  fault_resp_ctrl #(
    .TICK_DIV(P), .TIMER_W(8),
    .SLOW_T0(6), .SLOW_T1(8), .SLOW_T2(10), .SLOW_T3(12),
    .FAST_T0(2), .FAST_T1(3), .FAST_T2(4), .FAST_T3(5)
  ) uut (.*);

  int  n_chk = 0, n_bad = 0;
  bit  done = 0;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_win(string req, int n, int lo, int hi);
    n_chk++;
    if (n < lo || n > hi) begin
      n_bad++;
      $display("FAIL %s: actual %0d edges expected %0d..%0d", req, n, lo, hi);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_clear;
    @(negedge clk) clear_i = 1'b1;
    @(negedge clk) clear_i = 1'b0;
  endtask

  task automatic drive_src(int src, logic v);
    @(negedge clk);
    case (src)
      0:       oc_hs_i[0] = v;
      1:       uv_i = v;
      default: ot_sd_i = v;
    endcase
  endtask

  function automatic int sts_of(int src);
    case (src)
      0:       return int'(oc_sts_o[0]);
      1:       return int'(uv_sts_o);
      default: return int'(ot_sts_o);
    endcase
  endfunction

  // R2 R6 R7: auto-retry release window for a source, mode and table entry
  task automatic t_retry(string req, int src, int mode, bit slow, int sel);
    int t, n;
    oc_mode_i  = 3'(mode);
    uv_mode_i  = 2'(mode);
    ot_mode_i  = 2'(mode);
    slow_sel_i = slow ? 2'(sel) : 2'(3 - sel);
    fast_sel_i = slow ? 2'(3 - sel) : 2'(sel);
    t = slow ? ST[sel] : FT[sel];
    drive_src(src, 1'b1);
    edges(1);
    check({req, " status set"}, sts_of(src), 1);
    edges(1);
    check({req, " hiz while active"}, int'(drv_hiz_o), 1);
    check({req, " fault_n while active"}, int'(fault_n_o), 0);
    check({req, " R12 summary"}, int'(dev_fault_o), 1);
    edges(3);
    drive_src(src, 1'b0);
    n = 0;
    for (int k = 0; k < 400; k++) begin
      @(posedge clk); #1;
      n++;
      if (!drv_hiz_o) break;
    end
    check_win({req, " release window"}, n, 4 + (t - 1) * P, 3 + t * P);
    check({req, " fault_n released"}, int'(fault_n_o), 1);
    pulse_clear();
    check({req, " R13 status cleared"}, sts_of(src), 0);
  endtask

  task automatic t_reset;
    check("R1 fault_n", int'(fault_n_o), 1);
    check("R1 hiz", int'(drv_hiz_o), 0);
    check("R1 summary", int'(dev_fault_o), 0);
    check("R1 status", int'({oc_sts_o, uv_sts_o, ot_sts_o, otw_sts_o, spi_sts_o}), 0);
  endtask

  task automatic t_latch;
    oc_mode_i = 3'd2;
    @(negedge clk) oc_ls_i[1] = 1'b1;
    edges(2);
    check("R3 hiz active", int'(drv_hiz_o), 1);
    @(negedge clk) oc_ls_i[1] = 1'b0;
    edges(30);
    check("R3 hiz held", int'(drv_hiz_o), 1);
    check("R3 summary held", int'(dev_fault_o), 1);
    check("R3 R11 low-side B bit", int'(oc_sts_o), 6'b010000);
    @(negedge clk) oc_ls_i[1] = 1'b1;
    pulse_clear();
    oc_ls_i[1] = 1'b0;
    edges(10);
    check("R13 clear under fault keeps latch", int'(drv_hiz_o), 1);
    check("R13 clear under fault keeps bit", int'(oc_sts_o[4]), 1);
    pulse_clear();
    edges(1);
    check("R3 released by clear", int'(drv_hiz_o), 0);
    check("R3 fault_n after clear", int'(fault_n_o), 1);
    check("R13 bit cleared", int'(oc_sts_o), 0);
  endtask

  task automatic t_report_only;
    oc_mode_i = 3'd3;
    @(negedge clk) oc_hs_i[2] = 1'b1;
    edges(2);
    check("R4 reported", int'(fault_n_o), 0);
    check("R4 no hiz", int'(drv_hiz_o), 0);
    check("R4 R11 high-side C bit", int'(oc_sts_o), 6'b000100);
    @(negedge clk) oc_hs_i[2] = 1'b0;
    edges(2);
    check("R4 report ends", int'(fault_n_o), 1);
    pulse_clear();
  endtask

  task automatic t_disabled;
    oc_mode_i = 3'd7;
    @(negedge clk) oc_ls_i[2] = 1'b1;
    edges(3);
    check("R5 no report", int'(fault_n_o), 1);
    check("R5 no hiz", int'(drv_hiz_o), 0);
    check("R5 no status", int'(oc_sts_o), 0);
    @(negedge clk) oc_ls_i[2] = 1'b0;
    edges(1);
  endtask

  task automatic t_retrigger;
    int n;
    bit dropped = 0;
    oc_mode_i = 3'd1;
    fast_sel_i = 2'd3;
    @(negedge clk) oc_hs_i[1] = 1'b1;
    edges(2);
    @(negedge clk) oc_hs_i[1] = 1'b0;
    edges(8);
    check("R8 still retrying", int'(drv_hiz_o), 1);
    @(negedge clk) oc_hs_i[1] = 1'b1;
    edges(2);
    check("R8 hiz on return", int'(drv_hiz_o), 1);
    @(negedge clk) oc_hs_i[1] = 1'b0;
    n = 0;
    for (int k = 0; k < 400; k++) begin
      @(posedge clk); #1;
      n++;
      if (!drv_hiz_o) begin dropped = 1; break; end
    end
    check("R8 released", int'(dropped), 1);
    check_win("R8 full restart", n, 4 + (FT[3] - 1) * P, 3 + FT[3] * P);
    pulse_clear();
  endtask

  task automatic t_warning;
    otw_en_i = 1'b0;
    @(negedge clk) otw_i = 1'b1;
    edges(2);
    check("R9 disabled no report", int'(fault_n_o), 1);
    check("R9 status always", int'(otw_sts_o), 1);
    @(negedge clk) otw_i = 1'b0;
    pulse_clear();
    check("R9 status cleared", int'(otw_sts_o), 0);
    otw_en_i = 1'b1;
    @(negedge clk) otw_i = 1'b1;
    edges(2);
    check("R9 enabled report", int'(fault_n_o), 0);
    check("R9 no hiz", int'(drv_hiz_o), 0);
    @(negedge clk) otw_i = 1'b0;
    edges(2);
    check("R9 report ends", int'(fault_n_o), 1);
    pulse_clear();
    otw_en_i = 1'b0;
  endtask

  task automatic t_spi;
    spi_dis_i = 1'b1;
    @(negedge clk) spi_flt_i = 1'b1;
    edges(2);
    check("R10 ignored no report", int'(fault_n_o), 1);
    check("R10 ignored no status", int'(spi_sts_o), 0);
    @(negedge clk) spi_flt_i = 1'b0;
    spi_dis_i = 1'b0;
    @(negedge clk) spi_flt_i = 1'b1;
    edges(2);
    check("R10 reported", int'(fault_n_o), 0);
    check("R10 status", int'(spi_sts_o), 1);
    check("R10 no hiz", int'(drv_hiz_o), 0);
    @(negedge clk) spi_flt_i = 1'b0;
    edges(2);
    check("R10 report ends", int'(fault_n_o), 1);
    pulse_clear();
    check("R10 status cleared", int'(spi_sts_o), 0);
  endtask

  task automatic t_oc_bits;
    oc_mode_i = 3'd3;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk) {oc_ls_i, oc_hs_i} = 6'(1 << i);
      edges(1);
      check($sformatf("R11 switch %0d bit", i), int'(oc_sts_o), 1 << i);
      @(negedge clk) {oc_ls_i, oc_hs_i} = '0;
      edges(2);
      pulse_clear();
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_retry("R2 slow sel0", 0, 0, 1'b1, 0);
    t_retry("R7 slow sel3", 0, 0, 1'b1, 3);
    t_retry("R2 fast sel2", 0, 1, 1'b0, 2);
    t_retry("R6 oc code5 fast sel1", 0, 5, 1'b0, 1);
    t_retry("R7 uv slow sel1", 1, 0, 1'b1, 1);
    t_retry("R6 uv code2 fast sel0", 1, 2, 1'b0, 0);
    t_retry("R7 ot fast sel3", 2, 1, 1'b0, 3);
    t_latch();
    t_report_only();
    t_disabled();
    t_retrigger();
    t_warning();
    t_spi();
    t_oc_bits();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end
endmodule